// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter with Snapshot Register

This block pairs an up/down counter with a separate holding register. The counter moves on the rising edge of its own clock. It steps up or down by one, and only when both count enables are high. It wraps at its modulus: sixteen for a plain binary stage, ten for a decade (BCD) stage. A second clock, independent of the first, copies the live count into the holding register. The holding register is never cleared.

A select input chooses what appears on the tri-state data outputs: the live count or the held snapshot. An active-low output enable lets several stages share a bus. An active-low ripple-carry output flags the terminal state, so stages can be chained into wider counters.

Two build-time parameters set the variant:
- the modulus;
- whether the active-low clear acts on the next counter clock edge or at once.

Top module: `updn_cnt_reg`

## Requirements
- R1: The counter value changes only on a rising edge of `cnt_clk` (or when an asynchronous clear is applied). Edges of `reg_clk` leave it unchanged.
- R2: With `up_ndown` high and both enables high, the counter adds one per `cnt_clk` edge, and wraps from MODULUS-1 to 0.
- R3: With `up_ndown` low and both enables high, the counter subtracts one per edge, and wraps from 0 to MODULUS-1.
- R4: If either `en_p` or `en_t` is low at a `cnt_clk` edge, the counter holds its value.
- R5: Each rising edge of `reg_clk` copies the current count into the holding register. A clear leaves the holding register untouched.
- R6: With `oe_n` low, `q_out` shows the live count when `sel_reg` is 0 and the held value when `sel_reg` is 1.
- R7: With `oe_n` high, `q_out` is released to high impedance, and another driver on the same bus sets its value.
- R8: `rco_n` is 0 exactly when `en_t` is high and the count is at its terminal state: MODULUS-1 when counting up, 0 when counting down. `en_p` has no effect on it.
- R9: While `clr_n` is low, the count goes to 0. With CLR_STYLE = CLR_SYNC this happens at the next `cnt_clk` edge. With CLR_ASYNC it happens at once, before any edge. The clear overrides counting.
- R10: The count never leaves the range 0 to MODULUS-1. MODULUS = 10 gives a decade stage counting 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| reg_clk | input | 1 | Snapshot clock for the holding register, rising edge |
| up_ndown | input | 1 | 1 = count up, 0 = count down |
| en_p | input | 1 | Count enable, parallel |
| en_t | input | 1 | Count enable, trickle; also gates the ripple carry |
| clr_n | input | 1 | Active-low counter clear |
| sel_reg | input | 1 | Output source: 0 = counter, 1 = holding register |
| oe_n | input | 1 | Active-low output enable |
| q_out | output | $clog2(MODULUS) (4) | Tri-state data outputs |
| rco_n | output | 1 | Active-low ripple-carry output |

## Verification
Two instances are driven from the same inputs: a binary stage with a synchronous clear, and a decade stage with an asynchronous clear. Because they share every input, the two clear styles and the two wrap points are told apart side by side.

Directed runs cover the following:
- long up and down walks, which hit every wrap;
- holding with each enable low on its own;
- a parked terminal state, with the ripple carry toggled through `en_t`;
- a snapshot taken and then a clear, followed by reading the register;
- a bus takeover while the outputs are disabled.

A seeded random phase then mixes direction, the enables, rare clears, source selection and irregular snapshot timing. Every sampled output in that phase is compared with a reference model kept in the bench.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

   // How the active-low clear reaches the counter
   typedef enum logic {
      CLR_SYNC  = 1'b0,
      CLR_ASYNC = 1'b1
   } clr_style_e;

endpackage

// File: rtl/ucr_count.sv
module ucr_count
   import ucr_pkg::*;
#(
   parameter int         MODULUS   = 16,
   parameter clr_style_e CLR_STYLE = CLR_SYNC,
   parameter int         DW        = $clog2(MODULUS)
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          up_ndown,
   input  logic          en_p,
   input  logic          en_t,
   output logic [DW-1:0] cnt,
   output logic          rco_n
);

   localparam logic [DW-1:0] TOP  = DW'(MODULUS - 1);
   localparam logic [DW-1:0] ONE  = DW'(1);
   localparam logic [DW-1:0] ZERO = '0;

   logic [DW-1:0] nxt;
   logic          at_term;

   always_comb begin
      nxt = cnt;
      if (en_p && en_t) begin
         if (up_ndown) nxt = (cnt == TOP)  ? ZERO : cnt + ONE;
         else          nxt = (cnt == ZERO) ? TOP  : cnt - ONE;
      end
   end

   generate
      if (CLR_STYLE == CLR_ASYNC) begin : g_aclr
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) cnt <= ZERO;
            else        cnt <= nxt;
         end
      end else begin : g_sclr
         always_ff @(posedge clk) begin
            if (!clr_n) cnt <= ZERO;
            else        cnt <= nxt;
         end
      end
   endgenerate

   assign at_term = up_ndown ? (cnt == TOP) : (cnt == ZERO);
   assign rco_n   = !(en_t && at_term);

endmodule

// File: rtl/ucr_hold.sv
module ucr_hold #(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   // Snapshot register: no clear, keeps its value between edges
   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/ucr_outsel.sv
module ucr_outsel #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] cnt,
   input  logic [DW-1:0] hold,
   input  logic          sel_reg,
   input  logic          oe_n,
   output wire  [DW-1:0] q
);

   logic [DW-1:0] pick;

   assign pick = sel_reg ? hold : cnt;
   assign q    = oe_n ? {DW{1'bz}} : pick;

endmodule

// File: rtl/updn_cnt_reg.sv
module updn_cnt_reg
   import ucr_pkg::*;
#(
   parameter int         MODULUS   = 16,
   parameter clr_style_e CLR_STYLE = CLR_SYNC
) (
   input  logic                       cnt_clk,
   input  logic                       reg_clk,
   input  logic                       up_ndown,
   input  logic                       en_p,
   input  logic                       en_t,
   input  logic                       clr_n,
   input  logic                       sel_reg,
   input  logic                       oe_n,
   output wire  [$clog2(MODULUS)-1:0] q_out,
   output logic                       rco_n
);

   localparam int DW = $clog2(MODULUS);

   generate
      if (MODULUS < 2) begin : g_bad_mod
         $error("updn_cnt_reg: MODULUS must be at least 2");
      end
   endgenerate

   logic [DW-1:0] cnt_val;
   logic [DW-1:0] hold_val;

   ucr_count #(
      .MODULUS  (MODULUS),
      .CLR_STYLE(CLR_STYLE),
      .DW       (DW)
   ) u_count (
      .clk     (cnt_clk),
      .clr_n   (clr_n),
      .up_ndown(up_ndown),
      .en_p    (en_p),
      .en_t    (en_t),
      .cnt     (cnt_val),
      .rco_n   (rco_n)
   );

   ucr_hold #(.DW(DW)) u_hold (
      .clk(reg_clk),
      .d  (cnt_val),
      .q  (hold_val)
   );

   ucr_outsel #(.DW(DW)) u_out (
      .cnt    (cnt_val),
      .hold   (hold_val),
      .sel_reg(sel_reg),
      .oe_n   (oe_n),
      .q      (q_out)
   );

endmodule

// File: rtl/ucr_chk.sv
module ucr_chk #(
   parameter int MODULUS = 16,
   parameter int DW      = $clog2(MODULUS)
) (
   input logic          cnt_clk,
   input logic          reg_clk,
   input logic          clr_n,
   input logic          up_ndown,
   input logic          en_p,
   input logic          en_t,
   input logic [DW-1:0] cnt,
   input logic [DW-1:0] hold,
   input logic          rco_n
);

   localparam logic [DW-1:0] TOP = DW'(MODULUS - 1);

   // R2
   up_step_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      (en_p && en_t && up_ndown && cnt != TOP) |=> (cnt == DW'($past(cnt) + DW'(1))));

   // R2
   up_wrap_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      (en_p && en_t && up_ndown && cnt == TOP) |=> (cnt == '0));

   // R3
   dn_step_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      (en_p && en_t && !up_ndown && cnt != '0) |=> (cnt == DW'($past(cnt) - DW'(1))));

   // R3
   dn_wrap_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      (en_p && en_t && !up_ndown && cnt == '0) |=> (cnt == TOP));

   // R4
   hold_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      !(en_p && en_t) |=> $stable(cnt));

   // R5
   snap_chk: assert property (@(negedge reg_clk) disable iff (!clr_n)
      hold == cnt);

   // R8
   rco_gate_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      !en_t |-> rco_n);

   // R8
   rco_term_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      !rco_n |-> (cnt == TOP || cnt == '0));

   // R10
   range_chk: assert property (@(posedge cnt_clk) disable iff (!clr_n)
      cnt <= TOP);

endmodule

bind updn_cnt_reg ucr_chk #(.MODULUS(MODULUS)) u_chk (
   .cnt_clk (cnt_clk),
   .reg_clk (reg_clk),
   .clr_n   (clr_n),
   .up_ndown(up_ndown),
   .en_p    (en_p),
   .en_t    (en_t),
   .cnt     (cnt_val),
   .hold    (hold_val),
   .rco_n   (rco_n)
);

// File: tb/sim_updn_cnt_reg.sv
module sim_updn_cnt_reg;
   import ucr_pkg::*;

   logic cnt_clk = 1'b0;
   logic reg_clk = 1'b0;
   logic up = 1'b1, ep = 1'b0, et = 1'b0, clr_n = 1'b0, sel = 1'b0, oe_n = 1'b0, drv = 1'b0;
   wire  [3:0] q0, q1;
   logic rco0, rco1;

   // Foreign bus driver used for the high-impedance test
   assign q0 = drv ? 4'hA : 4'bzzzz;
   assign q1 = drv ? 4'hA : 4'bzzzz;

   always #4 cnt_clk = ~cnt_clk;   // 125 MHz

   updn_cnt_reg #(.MODULUS(16), .CLR_STYLE(CLR_SYNC)) u0 (
      .cnt_clk(cnt_clk), .reg_clk(reg_clk), .up_ndown(up), .en_p(ep), .en_t(et),
      .clr_n(clr_n), .sel_reg(sel), .oe_n(oe_n), .q_out(q0), .rco_n(rco0));

   updn_cnt_reg #(.MODULUS(10), .CLR_STYLE(CLR_ASYNC)) u1 (
      .cnt_clk(cnt_clk), .reg_clk(reg_clk), .up_ndown(up), .en_p(ep), .en_t(et),
      .clr_n(clr_n), .sel_reg(sel), .oe_n(oe_n), .q_out(q1), .rco_n(rco1));

   int checks = 0, fails = 0;
   int m0 = 0, m1 = 0, r0 = 0, r1 = 0;
   bit done = 1'b0;

   function automatic int nxt(int v, bit u, int md);
      if (u) return (v == md - 1) ? 0 : v + 1;
      return (v == 0) ? md - 1 : v - 1;
   endfunction

   function automatic int rco_exp(int v, bit u, bit t, int md);
      return (t && (u ? (v == md - 1) : (v == 0))) ? 0 : 1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic snap();
      reg_clk = 1'b1;
      #1 reg_clk = 1'b0;
      r0 = m0;
      r1 = m1;
   endtask

   // One counter cycle: drive at the falling edge, check the outputs
   // before the rising edge, then advance the model after it.
   task automatic cyc(input bit u, input bit p, input bit t, input bit c,
                      input bit s, input bit dosnap, input string tag);
      int e0, e1;
      @(negedge cnt_clk);
      up = u; ep = p; et = t; clr_n = c; sel = s;
      #1;
      if (!c) m1 = 0;                       // asynchronous clear of u1 (R9)
      if (dosnap) snap();
      #1;
      e0 = s ? r0 : m0;
      e1 = s ? r1 : m1;
      chk(q0 == 4'(e0), tag, int'(q0), e0);
      chk(q1 == 4'(e1), tag, int'(q1), e1);
      chk(int'(rco0) == rco_exp(m0, u, t, 16), tag, int'(rco0), rco_exp(m0, u, t, 16));
      chk(int'(rco1) == rco_exp(m1, u, t, 10), tag, int'(rco1), rco_exp(m1, u, t, 10));
      @(posedge cnt_clk);
      #1;
      if (!c) begin
         m0 = 0;
         m1 = 0;
      end else if (p && t) begin
         m0 = nxt(m0, u, 16);
         m1 = nxt(m1, u, 10);
      end
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      // R9: reset state after clear
      cyc(1, 0, 0, 0, 0, 0, "R9");
      cyc(1, 0, 0, 0, 0, 1, "R9");
      cyc(1, 0, 0, 1, 0, 0, "R9");
      // R2 and R10: up walk through both wrap points
      for (int i = 0; i < 20; i++) cyc(1, 1, 1, 1, 0, 0, "R2/R10");
      // R3: down walk through both wrap points
      for (int i = 0; i < 22; i++) cyc(0, 1, 1, 1, 0, 0, "R3");
      // R4: each enable low on its own
      for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, 0, "R4");
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, 0, 0, "R4");
      // R9: asynchronous versus synchronous clear from a nonzero count
      cyc(1, 1, 1, 0, 0, 0, "R9");
      // R8: parked at zero counting down, carry follows en_t only
      cyc(0, 0, 1, 1, 0, 0, "R8");
      cyc(0, 0, 0, 1, 0, 0, "R8");
      cyc(0, 1, 0, 1, 0, 0, "R8");
      // R1: snapshots between counter edges leave the count alone
      for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 1, "R1");
      @(negedge cnt_clk);
      ep = 1'b0;
      repeat (3) begin snap(); #1; end
      chk(q0 == 4'(m0), "R1", int'(q0), m0);
      chk(q1 == 4'(m1), "R1", int'(q1), m1);
      // R5: clear does not disturb the held value
      cyc(1, 1, 1, 0, 1, 0, "R5");
      cyc(1, 0, 0, 1, 1, 0, "R5");
      // R7: outputs released, bus taken by a foreign driver
      @(negedge cnt_clk);
      oe_n = 1'b1; drv = 1'b1;
      #1;
      chk(q0 == 4'hA, "R7", int'(q0), 10);
      chk(q1 == 4'hA, "R7", int'(q1), 10);
      drv = 1'b0; oe_n = 1'b0;
      #1;
      chk(q0 == 4'(sel ? r0 : m0), "R7", int'(q0), sel ? r0 : m0);
      // R6: random mix compared against the model
      for (int i = 0; i < 400; i++) begin
         cyc(1'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0,
             ($urandom % 25) != 0, 1'($urandom), ($urandom % 3) == 0, "R6");
      end
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule